// File: doc/BRIEF.md
# Indexed Real-Time Clock Register Window

This block exposes a small real-time clock register file through two access points: an index register that selects one of fourteen locations, and a data port that reads or writes the selected location. The ten lowest locations are plain clock bytes (seconds, minutes, hours, weekday, day of month, month, year, plus the alarm bytes between them). The four locations above them are status registers. Only a narrow set of values may be written to them, and any other value is refused and reported on a one-cycle error pulse.

A periodic interrupt generator sits beside the register file. It is gated by the periodic-enable bit of the second status register. While that bit is set, the generator emits a one-cycle pulse every `PERIOD` clock cycles and rearms at once. Reading the first status register flips its update-in-progress bit on every access. Software polling for an update edge therefore always sees the bit change. The reset contents of the clock bytes come from parameters. The weekday and the month parameters count from zero and are stored counting from one.

Top module: `rtc_indexed_regs`

## Requirements
- R1: After reset the index is 0, status A (index 0xA) reads 0xA6 on the first read, status B (index 0xB) holds 0x46, and clock bytes 0,2,4,6,7,8,9 hold INIT_SEC, INIT_MIN, INIT_HOUR, INIT_WDAY0+1, INIT_MDAY, INIT_MON0+1, INIT_YEAR, with bytes 1,3,5 at zero.
- R2: An index write of a value 0x0D or below is stored. A larger value leaves the index unchanged and raises `err` for one cycle, in the cycle after the write.
- R3: At indices 0x0 to 0x9 the data port writes and reads back a plain byte. Read data appears on `rdata` with `rd_valid` high in the cycle after the read strobe.
- R4: Every read of status A inverts bit 7 (update in progress) and returns the inverted value. Bits 6..0 are unchanged.
- R5: A write of 0x26 to status A is stored, which clears bit 7. Any other value is refused, status A is unchanged, and `err` pulses.
- R6: A write to status B is accepted only if its bits other than bit 6 (periodic enable) and bit 3 (square-wave enable) equal 0x06. Otherwise status B is unchanged and `err` pulses.
- R7: Reads of indices 0xC and 0xD return 0x00. Writes to them change nothing and pulse `err`.
- R8: While bit 6 of status B is set, `irq` is high for exactly one cycle out of every PERIOD cycles.
- R9: Clearing bit 6 of status B stops `irq`. Setting it again gives the first pulse PERIOD cycles after the write. Writing it set while it is already set leaves the pulse phase unchanged.
- R10: When strobes coincide, an index write takes priority over a data write, and a data write takes priority over a data read. Only the highest-priority operation has any effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_wr | input | 1 | Load the index register from `wdata` |
| dat_wr | input | 1 | Write `wdata` to the selected location |
| dat_rd | input | 1 | Read the selected location |
| wdata | input | 8 | Write data for index or location |
| rdata | output | 8 | Read data, registered |
| rd_valid | output | 1 | `rdata` holds the result of the read in the previous cycle |
| err | output | 1 | One-cycle pulse for a refused access |
| irq | output | 1 | One-cycle periodic interrupt pulse |

## Verification
A strobe presented before clock edge e has its result on `rdata`, `rd_valid` and `err` after edge e, so the bench drives strobes on a falling edge and samples on the next falling edge. Once an enable write has landed at edge e, the first `irq` is due after edge e+PERIOD, and each later pulse follows exactly PERIOD cycles on. The bench measures these distances with a cycle counter that advances on rising edges and is read on falling edges. A register model in the bench predicts every read value, including the bit-7 flip of status A, across sweeps over all 256 index values and all 256 status-register write values.

// File: rtl/rtc_regs_pkg.sv
package rtc_regs_pkg;
  localparam int IDX_W      = 4;
  localparam int DATA_BYTES = 10;
  localparam logic [IDX_W-1:0] IDX_LAST   = 4'hD;
  localparam logic [IDX_W-1:0] IDX_STAT_A = 4'hA;
  localparam logic [IDX_W-1:0] IDX_STAT_B = 4'hB;
  localparam logic [IDX_W-1:0] IDX_STAT_C = 4'hC;
  localparam int A_UIP_BIT  = 7;
  localparam logic [7:0] A_RESET    = 8'h26;
  localparam int B_PIE_BIT  = 6;
  localparam logic [7:0] B_RESET    = 8'h46;
  localparam logic [7:0] B_FIXED    = 8'h06;
  localparam logic [7:0] B_FREE     = 8'h48;
endpackage

// File: rtl/rtc_index_reg.sv
module rtc_index_reg
  import rtc_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [7:0]       wdata,
  output logic [IDX_W-1:0] idx,
  output logic             bad
);
  logic             take;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    take  = load && (wdata <= {4'h0, IDX_LAST});
    bad   = load && !take;
    idx_d = take ? wdata[IDX_W-1:0] : idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx <= '0;
    else if (take) idx <= idx_d;
  end
endmodule

// File: rtl/rtc_data_bank.sv
module rtc_data_bank
  import rtc_regs_pkg::*;
#(
  parameter int INIT_SEC   = 0,
  parameter int INIT_MIN   = 0,
  parameter int INIT_HOUR  = 0,
  parameter int INIT_WDAY0 = 0,
  parameter int INIT_MDAY  = 1,
  parameter int INIT_MON0  = 0,
  parameter int INIT_YEAR  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rd_byte
);
  function automatic logic [7:0] reset_byte(int i);
    case (i)
      0:       return 8'(INIT_SEC);
      2:       return 8'(INIT_MIN);
      4:       return 8'(INIT_HOUR);
      6:       return 8'(INIT_WDAY0 + 1);
      7:       return 8'(INIT_MDAY);
      8:       return 8'(INIT_MON0 + 1);
      9:       return 8'(INIT_YEAR);
      default: return 8'h00;
    endcase
  endfunction

  logic [7:0] bytes_q [DATA_BYTES];

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_byte
    localparam logic [7:0] RV = reset_byte(g);
    logic en;
    assign en = we && (addr == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bytes_q[g] <= RV;
      else if (en) bytes_q[g] <= wdata;
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    for (int i = 0; i < DATA_BYTES; i++)
      if (addr == IDX_W'(i)) rd_byte = bytes_q[i];
  end
endmodule

// File: rtl/rtc_status_regs.sv
module rtc_status_regs
  import rtc_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [IDX_W-1:0] addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       stat_a,
  output logic [7:0]       stat_b,
  output logic [7:0]       rd_byte,
  output logic             bad
);
  logic [7:0] a_d, b_d;
  logic       a_en, b_en;

  always_comb begin
    a_d  = stat_a;
    b_d  = stat_b;
    a_en = 1'b0;
    b_en = 1'b0;
    bad  = 1'b0;
    if (wr) begin
      if (addr == IDX_STAT_A) begin
        if (wdata == A_RESET) begin a_d = wdata; a_en = 1'b1; end
        else bad = 1'b1;
      end else if (addr == IDX_STAT_B) begin
        if ((wdata & ~B_FREE) == B_FIXED) begin b_d = wdata; b_en = 1'b1; end
        else bad = 1'b1;
      end else if (addr >= IDX_STAT_C) begin
        bad = 1'b1;
      end
    end
    if (rd && addr == IDX_STAT_A) begin
      a_d[A_UIP_BIT] = ~stat_a[A_UIP_BIT];
      a_en = 1'b1;
    end
    case (addr)
      IDX_STAT_A: rd_byte = a_d;
      IDX_STAT_B: rd_byte = stat_b;
      default:    rd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stat_a <= A_RESET;
    else if (a_en) stat_a <= a_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stat_b <= B_RESET;
    else if (b_en) stat_b <= b_d;
  end
endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
  parameter int PERIOD = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic irq
);
  localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_d;

  always_comb begin
    irq_d = 1'b0;
    cnt_d = RELOAD;
    if (run) begin
      if (cnt_q == '0) irq_d = 1'b1;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RELOAD;
      irq   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq   <= irq_d;
    end
  end
endmodule

// File: rtl/rtc_indexed_regs.sv
module rtc_indexed_regs
  import rtc_regs_pkg::*;
#(
  parameter int PERIOD     = 1024,
  parameter int INIT_SEC   = 0,
  parameter int INIT_MIN   = 0,
  parameter int INIT_HOUR  = 0,
  parameter int INIT_WDAY0 = 0,
  parameter int INIT_MDAY  = 1,
  parameter int INIT_MON0  = 0,
  parameter int INIT_YEAR  = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       dat_wr,
  input  logic       dat_rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rd_valid,
  output logic       err,
  output logic       irq
);
  logic             do_wr, do_rd;
  logic [IDX_W-1:0] cur_idx;
  logic             bad_idx, bad_stat, in_bank;
  logic [7:0]       bank_byte, stat_byte, rd_d;
  logic [7:0]       stat_a_q, stat_b_q;

  assign do_wr   = dat_wr && !idx_wr;
  assign do_rd   = dat_rd && !idx_wr && !dat_wr;
  assign in_bank = cur_idx < IDX_W'(DATA_BYTES);

  rtc_index_reg u_index (
    .clk(clk), .rst_n(rst_n), .load(idx_wr), .wdata(wdata),
    .idx(cur_idx), .bad(bad_idx)
  );

  rtc_data_bank #(
    .INIT_SEC(INIT_SEC), .INIT_MIN(INIT_MIN), .INIT_HOUR(INIT_HOUR),
    .INIT_WDAY0(INIT_WDAY0), .INIT_MDAY(INIT_MDAY), .INIT_MON0(INIT_MON0),
    .INIT_YEAR(INIT_YEAR)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .we(do_wr && in_bank), .addr(cur_idx),
    .wdata(wdata), .rd_byte(bank_byte)
  );

  rtc_status_regs u_status (
    .clk(clk), .rst_n(rst_n), .wr(do_wr && !in_bank), .rd(do_rd && !in_bank),
    .addr(cur_idx), .wdata(wdata), .stat_a(stat_a_q), .stat_b(stat_b_q),
    .rd_byte(stat_byte), .bad(bad_stat)
  );

  rtc_periodic #(.PERIOD(PERIOD)) u_periodic (
    .clk(clk), .rst_n(rst_n), .run(stat_b_q[B_PIE_BIT]), .irq(irq)
  );

  assign rd_d = in_bank ? bank_byte : stat_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= 8'h00;
    else if (do_rd) rdata <= rd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      err      <= 1'b0;
    end else begin
      rd_valid <= do_rd;
      err      <= bad_idx || bad_stat;
    end
  end
endmodule

// File: rtl/rtc_indexed_regs_chk.sv
module rtc_indexed_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       idx_wr,
  input logic       dat_wr,
  input logic       dat_rd,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       rd_valid,
  input logic       err,
  input logic       irq,
  input logic [3:0] idx,
  input logic [7:0] stat_a,
  input logic [7:0] stat_b
);
  assert_idx_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= 4'hD);
  assert_bad_idx_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && wdata > 8'h0D) |=> (err && $stable(idx)));
  assert_uip_flips_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !idx_wr && !dat_wr && idx == 4'hA) |=> (stat_a[7] != $past(stat_a[7])));
  assert_a_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_a[6:0] == 7'h26);
  assert_b_fixed_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_b & 8'hB7) == 8'h06);
  assert_cd_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !idx_wr && !dat_wr && idx >= 4'hC) |=> (rdata == 8'h00));
  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_b[6] |=> !irq);
  assert_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && (idx_wr || dat_wr)) |=> !rd_valid);
endmodule

bind rtc_indexed_regs rtc_indexed_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .dat_wr(dat_wr), .dat_rd(dat_rd),
  .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .err(err), .irq(irq),
  .idx(cur_idx), .stat_a(stat_a_q), .stat_b(stat_b_q)
);

// File: tb/test_rtc_indexed_regs.sv
module test_rtc_indexed_regs;
  localparam int P = 12;
  localparam int SEC = 11, MIN = 22, HOUR = 13, WD0 = 4, MDAY = 27, MON0 = 10, YEAR = 99;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idx_wr = 1'b0, dat_wr = 1'b0, dat_rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rd_valid, err, irq;
  int         n_run = 0, n_fail = 0, cyc = 0;

  logic [7:0] m_bank [10];
  logic [7:0] m_a, m_b;
  logic [3:0] m_idx;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtc_indexed_regs #(
    .PERIOD(P), .INIT_SEC(SEC), .INIT_MIN(MIN), .INIT_HOUR(HOUR),
    .INIT_WDAY0(WD0), .INIT_MDAY(MDAY), .INIT_MON0(MON0), .INIT_YEAR(YEAR)
  ) i_rtc_indexed_regs (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .dat_wr(dat_wr), .dat_rd(dat_rd),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .err(err), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // All ops start and end at a falling edge; results sampled at the end.
  task automatic op(input bit iw, input bit dw, input bit dr, input logic [7:0] v);
    idx_wr = iw; dat_wr = dw; dat_rd = dr; wdata = v;
    @(negedge clk);
    idx_wr = 1'b0; dat_wr = 1'b0; dat_rd = 1'b0;
  endtask

  task automatic t_idx(input logic [7:0] v, input string tag);
    op(1, 0, 0, v);
    check(err == (v > 8'h0D), tag, err, v > 8'h0D);
    if (v <= 8'h0D) m_idx = v[3:0];
  endtask

  task automatic t_wr(input logic [7:0] v, input string tag);
    bit exp_err;
    exp_err = 1'b0;
    if (m_idx < 10) m_bank[m_idx] = v;
    else if (m_idx == 4'hA) begin if (v == 8'h26) m_a = v; else exp_err = 1'b1; end
    else if (m_idx == 4'hB) begin if ((v & 8'hB7) == 8'h06) m_b = v; else exp_err = 1'b1; end
    else exp_err = 1'b1;
    op(0, 1, 0, v);
    check(err == exp_err, tag, err, exp_err);
  endtask

  task automatic t_rd(input string tag);
    logic [7:0] e;
    if (m_idx < 10) e = m_bank[m_idx];
    else if (m_idx == 4'hA) begin m_a[7] = ~m_a[7]; e = m_a; end
    else if (m_idx == 4'hB) e = m_b;
    else e = 8'h00;
    op(0, 0, 1, 8'h00);
    check(rd_valid && rdata == e, tag, rdata, e);
  endtask

  task automatic wait_irq(output int at);
    at = -1;
    for (int k = 0; k < 4 * P; k++) begin
      @(negedge clk);
      if (irq) begin at = cyc; break; end
    end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int t0, t1, t2, seen;
    for (int i = 0; i < 10; i++) m_bank[i] = 8'h00;
    m_bank[0] = SEC; m_bank[2] = MIN; m_bank[4] = HOUR; m_bank[6] = WD0 + 1;
    m_bank[7] = MDAY; m_bank[8] = MON0 + 1; m_bank[9] = YEAR;
    m_a = 8'h26; m_b = 8'h46; m_idx = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(err == 0 && rd_valid == 0, "R1 outputs idle", {err, rd_valid}, 0);
    // R1: reset contents, index 0 at reset
    t_rd("R1 byte at reset index");
    for (int i = 1; i < 14; i++) begin t_idx(8'(i), "R2 idx"); t_rd("R1 reset value"); end
    t_idx(8'h0A, "R2 idx"); t_rd("R4 second A read");

    // R3: data bytes with two patterns
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 10; i++) begin
        t_idx(8'(i), "R2 idx");
        t_wr(p ? 8'(8'hFF - i * 7) : 8'(8'h30 + i), "R3 write");
        t_rd("R3 readback");
      end

    // R2: sweep all index values, observe via readback
    for (int v = 0; v < 256; v++) begin
      t_idx(8'(v), "R2 index sweep");
      t_rd("R2 index readback");
    end

    // R5/R4: sweep writes to A
    t_idx(8'h0A, "R2 idx");
    for (int v = 0; v < 256; v++) begin
      t_wr(8'(v), "R5 A write");
      t_rd("R4 A read");
    end

    // R7: C and D
    for (int i = 12; i < 14; i++) begin
      t_idx(8'(i), "R2 idx");
      t_wr(8'hFF, "R7 write flagged");
      t_rd("R7 read zero");
    end

    // R6: sweep writes to B, end disabled
    t_idx(8'h0B, "R2 idx");
    for (int v = 0; v < 256; v++) begin
      t_wr(8'(v), "R6 B write");
      t_rd("R6 B read");
    end
    t_wr(8'h06, "R6 disable");

    // R9: no pulses while disabled
    seen = 0;
    for (int k = 0; k < 3 * P; k++) begin @(negedge clk); if (irq) seen++; end
    check(seen == 0, "R9 quiet when disabled", seen, 0);

    // R9: enable, first pulse PERIOD cycles after the write edge
    t_wr(8'h4E, "R6 enable");
    t0 = cyc;
    wait_irq(t1);
    check(t1 - t0 == P, "R9 first pulse delay", t1 - t0, P);
    @(negedge clk);
    check(irq == 0, "R8 single cycle pulse", irq, 0);
    wait_irq(t2);
    check(t2 - t1 == P, "R8 pulse interval", t2 - t1, P);
    // R9: re-enable while running keeps phase
    repeat (3) @(negedge clk);
    t_wr(8'h46, "R9 re-enable");
    wait_irq(t1);
    check(t1 - t2 == P, "R9 phase kept", t1 - t2, P);
    wait_irq(t2);
    check(t2 - t1 == P, "R8 pulse interval again", t2 - t1, P);

    // R10: priority
    t_idx(8'h02, "R2 idx");
    t_wr(8'h5A, "R3 write");
    op(1, 1, 0, 8'h03); m_idx = 4'h3;
    check(err == 0, "R10 idx over write", err, 0);
    t_rd("R10 byte 3 untouched");
    t_idx(8'h02, "R2 idx");
    t_rd("R10 byte 2 untouched");
    op(0, 1, 1, 8'hC3); m_bank[2] = 8'hC3;
    check(rd_valid == 0, "R10 write over read", rd_valid, 0);
    t_rd("R10 write landed");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule